// File: doc/BRIEF.md
# Bit-Serial Dual Score Incrementer

This block keeps two 4-bit player scores in a single 8-bit shift register, one nibble per player, and adds points without a parallel adder. Each shift strobe moves the register one place, least significant bit first. The bit leaving the bottom stage is combined with a one-bit inverted-carry latch and fed back in at the top. Four shifts make up one window. A window passes the lower nibble through the carry stage and exchanges the two nibbles. A scan line has one window near its middle and another near horizontal sync, so the two players take turns at the carry stage.

A point request for a player is held until that player's nibble next passes through a window. At the start of that window a carry is injected, so that the nibble comes out incremented by one. Both scores are presented as plain binary values between windows. Decimal or seven-segment decoding happens elsewhere.

Top module: `dual_score_serial`

## Requirements
- R1: While `rst_n` is low, and after it is released, both scores read 0, and the first window serves player A.
- R2: Each clock with `mid_shift` or `hs_shift` high, or both, makes exactly one shift. Four shifts form a window. Windows alternate between player A, player B, player A and so on, whichever strobe drives them.
- R3: A request on `pt_a` that is registered before the first shift of an A window raises `score_a` by one when that window ends, and leaves `score_b` unchanged.
- R4: A request on `pt_b` that is registered before the first shift of a B window raises `score_b` by one when that window ends, and leaves `score_a` unchanged.
- R5: A score of 15 that is incremented becomes 0, and the discarded carry does not reach the other score.
- R6: A request raised in the same cycle as the first shift of its player's window, or later in that window, is not applied in that window. It is applied at the end of the player's next window.
- R7: Any number of requests for one player before one of that player's windows give a single increment.
- R8: Between windows the scores change only on a shift strobe, and the carry latch is back in its no-carry state after every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mid_shift | input | 1 | Shift strobe for the mid-line window |
| hs_shift | input | 1 | Shift strobe for the sync window |
| pt_a | input | 1 | Point request for player A |
| pt_b | input | 1 | Point request for player B |
| score_a | output | 4 | Player A score, valid between windows |
| score_b | output | 4 | Player B score, valid between windows |

## Verification
The hardest case to reach is a request that lands on the very cycle of its player's first shift. That request must miss the current window and be applied in the next one. The bench raises the request together with the first strobe pulse, then checks that the score is unchanged after that line and raised by one after the following line. A long sweep of request patterns over many lines drives both scores through the 15-to-0 wrap. After every window the bench compares the scores with values it computes modulo 16.

// File: rtl/dual_score_serial.sv
module dual_score_serial (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mid_shift,
  input  logic       hs_shift,
  input  logic       pt_a,
  input  logic       pt_b,
  output logic [3:0] score_a,
  output logic [3:0] score_b
);
  logic [7:0] sr;
  logic [1:0] cnt;
  logic       swapped, ncy, pend_a, pend_b;

  wire shift  = mid_shift | hs_shift;
  wire first  = (cnt == 2'd0);
  wire last   = (cnt == 2'd3);
  wire inject = swapped ? pend_b : pend_a;
  wire carry  = first ? inject : ~ncy;
  wire din    = sr[0] ~^ ~carry;
  wire take_a = shift & first & ~swapped;
  wire take_b = shift & first & swapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      swapped <= 1'b0;
      ncy     <= 1'b1;
    end else if (shift) begin
      sr  <= {din, sr[7:1]};
      cnt <= cnt + 2'd1;
      ncy <= last ? 1'b1 : ~(carry & sr[0]);
      if (last) swapped <= ~swapped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else begin
      pend_a <= (pend_a & ~take_a) | pt_a;
      pend_b <= (pend_b & ~take_b) | pt_b;
    end
  end

  assign score_a = swapped ? sr[7:4] : sr[3:0];
  assign score_b = swapped ? sr[3:0] : sr[7:4];
endmodule

// File: rtl/score_chk.sv
module score_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       shift,
  input logic [1:0] cnt,
  input logic       swapped,
  input logic       ncy,
  input logic       pend_a,
  input logic       pt_a,
  input logic [3:0] score_a,
  input logic [3:0] score_b
);
  // R8
  scores_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> ($stable(score_a) && $stable(score_b)));
  // R8
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && cnt == 2'd3) |=> ncy);
  // R2
  owner_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && cnt == 2'd3) |=> (swapped != $past(swapped)));
  // R2
  owner_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift && cnt == 2'd3) |=> $stable(swapped));
  // R7
  req_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && cnt == 2'd0 && !swapped && !pt_a) |=> !pend_a);
  // R6
  req_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_a |=> pend_a);
endmodule

bind dual_score_serial score_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shift(shift), .cnt(cnt), .swapped(swapped),
  .ncy(ncy), .pend_a(pend_a), .pt_a(pt_a), .score_a(score_a), .score_b(score_b)
);

// File: tb/sim_dual_score_serial.sv
module sim_dual_score_serial;
  logic clk = 0, rst_n = 0, mid_shift = 0, hs_shift = 0, pt_a = 0, pt_b = 0;
  logic [3:0] score_a, score_b;
  int total = 0, bad = 0;
  int ea = 0, eb = 0;

  always #10 clk = ~clk;

  dual_score_serial u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // sel: 0 mid, 1 hs, 2 both; ra/rb raise requests with the first pulse
  task automatic window(input int sel, input bit ra, input bit rb);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      mid_shift = (sel != 1);
      hs_shift  = (sel != 0);
      pt_a = (i == 0) && ra;
      pt_b = (i == 0) && rb;
      @(negedge clk);
      mid_shift = 0; hs_shift = 0; pt_a = 0; pt_b = 0;
      idle(1);
    end
  endtask

  task automatic request(input bit ra, input bit rb);
    @(negedge clk);
    pt_a = ra; pt_b = rb;
    @(negedge clk);
    pt_a = 0; pt_b = 0;
  endtask

  task automatic line(input int sa, input int sb);
    idle(3);
    window(sa, 0, 0);
    idle(3);
    window(sb, 0, 0);
    idle(2);
  endtask

  initial begin
    idle(3);
    chk("R1 reset a", score_a, 0);
    chk("R1 reset b", score_b, 0);
    rst_n = 1;
    idle(2);
    chk("R1 after release a", score_a, 0);
    chk("R1 after release b", score_b, 0);

    // first window serves A, second serves B
    request(1, 0);
    idle(2); window(0, 0, 0);
    chk("R2 R3 first window serves A", score_a, 1); ea = 1;
    chk("R3 b untouched", score_b, 0);
    request(0, 1);
    window(1, 0, 0);
    chk("R2 R4 second window serves B", score_b, 1); eb = 1;
    chk("R4 a untouched", score_a, ea);

    // sweep of request patterns, drives both through wrap
    for (int l = 0; l < 48; l++) begin
      bit ra = (l % 3) != 0;
      bit rb = (l % 5) != 2;
      request(ra, rb);
      if (l % 4 == 3) request(ra, rb);
      line(l % 3, (l + 1) % 3);
      ea = (ea + ra) % 16;
      eb = (eb + rb) % 16;
      chk("R3 R5 R7 sweep a", score_a, ea);
      chk("R4 R5 R7 sweep b", score_b, eb);
    end

    // explicit wrap of A only
    while (ea != 15) begin request(1, 0); line(0, 0); ea++; end
    eb = eb;
    chk("R5 a at 15", score_a, 15);
    request(1, 0); line(1, 1); ea = 0;
    chk("R5 a wraps", score_a, 0);
    chk("R5 b unaffected by carry", score_b, eb);

    // late request: same cycle as first shift of A window
    idle(2);
    window(0, 1, 0);
    window(1, 0, 0);
    chk("R6 not applied in its own window", score_a, ea);
    line(0, 1);
    ea = (ea + 1) % 16;
    chk("R6 applied next window", score_a, ea);
    chk("R6 b still", score_b, eb);

    // late request for B inside B window
    idle(2);
    window(0, 0, 0);
    window(2, 0, 1);
    chk("R6 b not applied in its own window", score_b, eb);
    line(2, 0);
    eb = (eb + 1) % 16;
    chk("R6 b applied next window", score_b, eb);

    // many requests merge
    for (int k = 0; k < 5; k++) request(1, 1);
    line(1, 2);
    ea = (ea + 1) % 16; eb = (eb + 1) % 16;
    chk("R7 merge a", score_a, ea);
    chk("R7 merge b", score_b, eb);

    // no strobe: scores hold while requests wait
    request(1, 1);
    idle(20);
    chk("R8 hold a", score_a, ea);
    chk("R8 hold b", score_b, eb);
    line(0, 0);
    ea = (ea + 1) % 16; eb = (eb + 1) % 16;
    chk("R8 pending then applied a", score_a, ea);
    chk("R8 pending then applied b", score_b, eb);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule